// File: doc/BRIEF.md
# Double-Precision Rounding and Packing Stage

This block is the last stage of a double-precision multiplier. It receives the unrounded product as a sign, a biased exponent and a 56-bit mantissa word. It rounds the mantissa to 52 fraction bits under one of four rounding modes, corrects the exponent when rounding ripples past the leading bit, clamps out-of-range results, and packs the outcome into a 64-bit binary64 word. It also raises overflow, underflow and inexact status flags.

The mantissa word is laid out from the top down. Bit 55 is a zero that absorbs a rounding carry. Bit 54 is the leading (hidden) bit. Bits 53..2 hold the fraction, bit 1 is the guard bit and bit 0 is the sticky bit. The exponent input is 12 bits wide, so an upstream sum that is already out of range can be passed in. A value of 0 together with a zero leading bit marks a subnormal operand. The block takes one operand per cycle, and each result appears one clock after its input strobe.

Top module: `fprnd_round_unit`

## Requirements
- R1: After reset, `out_valid_o`, `result_o` and all three flags are 0. A result and its flags are registered one cycle after `in_valid_i`. `out_valid_o` is high exactly in the cycle after a cycle with `in_valid_i` high.
- R2: Mode code 0 rounds to nearest with ties to even. The fraction is incremented when the guard bit (bit 1) is 1 and either the sticky bit (bit 0) or the fraction LSB (bit 2) is 1.
- R3: Mode code 1 rounds toward zero. The fraction is never incremented.
- R4: Mode code 2 rounds toward +infinity. It increments when the guard or sticky bit is set and the sign is 0.
- R5: Mode code 3 rounds toward -infinity. It increments when the guard or sticky bit is set and the sign is 1.
- R6: When the increment carries out of the leading bit, the mantissa is shifted right by one and the exponent is increased by 1.
- R7: A subnormal input (exponent 0, leading bit 0) whose increment reaches the leading-bit position produces exponent field 1 and no underflow.
- R8: If the exponent after rounding is 2047 or more, `overflow_o` is set. The result is infinity (exponent field 2047, fraction 0) under mode 0, and under the directed mode that points away from zero for the sign. Otherwise the result is the largest finite magnitude (exponent field 2046, fraction all ones). The sign bit is kept in every case.
- R9: `inexact_o` is set when the guard or sticky bit is 1, or when overflow occurs.
- R10: `underflow_o` is set when the final exponent field is 0 and the result is inexact. An exact subnormal or zero result raises no flag.
- R11: In cycles without `in_valid_i`, `result_o` and the flags hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| in_valid_i | input | 1 | Operand strobe |
| sign_i | input | 1 | Sign of the product |
| exp_i | input | 12 | Biased exponent before rounding |
| man_i | input | 56 | Carry zero, leading bit, 52 fraction bits, guard, sticky |
| mode_i | input | 2 | Rounding mode: 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| out_valid_o | output | 1 | Result valid |
| result_o | output | 64 | Packed binary64 result |
| overflow_o | output | 1 | Result exceeded the finite range |
| underflow_o | output | 1 | Result is tiny and inexact |
| inexact_o | output | 1 | Rounding discarded information |

## Verification
The block holds no state apart from its output register. A wrong increment decision, a missed carry correction or a bad saturation choice therefore shows up on `result_o` one clock after the operand that triggers it, and corrupts no later result. The stimulus concentrates on the inputs where these paths split: ties with an even or odd LSB, each sign under each directed mode, an all-ones fraction that carries into the exponent, an overflow under every mode and sign, and subnormals that either stay subnormal or promote to exponent 1. The reference model treats exponent and fraction as one integer, so a carry propagates into the exponent on its own, independently of the design's explicit shift-and-increment path.

// File: rtl/fprnd_pkg.sv
package fprnd_pkg;
  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'd0,
    RM_TO_ZERO   = 2'd1,
    RM_TO_POS    = 2'd2,
    RM_TO_NEG    = 2'd3
  } rmode_e;
endpackage

// File: rtl/fprnd_incr_decide.sv
// Decides whether the kept mantissa is bumped by one unit in the last place.
module fprnd_incr_decide
  import fprnd_pkg::*;
(
  input  logic   sign_i,
  input  rmode_e mode_i,
  input  logic   lsb_i,
  input  logic   guard_i,
  input  logic   sticky_i,
  output logic   inc_o,
  output logic   lost_o
);
  always_comb begin
    lost_o = guard_i | sticky_i;
    unique case (mode_i)
      RM_NEAR_EVEN: inc_o = guard_i & (sticky_i | lsb_i);
      RM_TO_ZERO:   inc_o = 1'b0;
      RM_TO_POS:    inc_o = lost_o & ~sign_i;
      RM_TO_NEG:    inc_o = lost_o & sign_i;
      default:      inc_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fprnd_mant_adjust.sv
// Adds the increment, renormalises on carry-out and corrects the exponent.
module fprnd_mant_adjust #(
  parameter int FRAC_W = 52,
  parameter int EXPI_W = 12
) (
  input  logic [EXPI_W-1:0] exp_i,
  input  logic [FRAC_W:0]   sig_i,   // leading bit + fraction
  input  logic              inc_i,
  output logic [EXPI_W:0]   exp_o,   // one bit wider so +1 never wraps
  output logic [FRAC_W-1:0] frac_o,
  output logic              carry_o
);
  logic [FRAC_W+1:0] sum;
  logic [EXPI_W:0]   exp_wide;

  always_comb begin
    sum      = {1'b0, sig_i} + (FRAC_W+2)'(inc_i);
    carry_o  = sum[FRAC_W+1];
    exp_wide = {1'b0, exp_i};
    if (carry_o) begin
      frac_o = sum[FRAC_W:1];
      exp_o  = exp_wide + 1'b1;
    end else begin
      frac_o = sum[FRAC_W-1:0];
      // a subnormal that rounds into the hidden-bit position becomes normal
      if (exp_i == '0 && sum[FRAC_W])
        exp_o = (EXPI_W+1)'(1);
      else
        exp_o = exp_wide;
    end
  end
endmodule

// File: rtl/fprnd_pack_sat.sv
// Range check, saturation by mode and sign, packing and status flags.
module fprnd_pack_sat
  import fprnd_pkg::*;
#(
  parameter int FRAC_W = 52,
  parameter int EXP_W  = 11,
  parameter int EXPI_W = EXP_W + 1,
  localparam int RES_W = 1 + EXP_W + FRAC_W,
  localparam int EXP_TOP = (1 << EXP_W) - 1
) (
  input  logic              sign_i,
  input  rmode_e            mode_i,
  input  logic [EXPI_W:0]   exp_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              lost_i,
  output logic [RES_W-1:0]  result_o,
  output logic              ovf_o,
  output logic              unf_o,
  output logic              inx_o
);
  logic to_inf;

  always_comb begin
    ovf_o  = exp_i >= (EXPI_W+1)'(EXP_TOP);
    to_inf = (mode_i == RM_NEAR_EVEN) ||
             (mode_i == RM_TO_POS && !sign_i) ||
             (mode_i == RM_TO_NEG &&  sign_i);
    if (ovf_o) begin
      if (to_inf)
        result_o = {sign_i, EXP_W'(EXP_TOP), {FRAC_W{1'b0}}};
      else
        result_o = {sign_i, EXP_W'(EXP_TOP - 1), {FRAC_W{1'b1}}};
    end else begin
      result_o = {sign_i, exp_i[EXP_W-1:0], frac_i};
    end
    inx_o = lost_i | ovf_o;
    unf_o = !ovf_o && (exp_i == '0) && lost_i;
  end
endmodule

// File: rtl/fprnd_round_unit.sv
module fprnd_round_unit
  import fprnd_pkg::*;
#(
  parameter int FRAC_W = 52,
  parameter int EXP_W  = 11,
  localparam int MAN_W  = FRAC_W + 4,
  localparam int EXPI_W = EXP_W + 1,
  localparam int RES_W  = 1 + EXP_W + FRAC_W,
  localparam int EXP_TOP = (1 << EXP_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid_i,
  input  logic              sign_i,
  input  logic [EXPI_W-1:0] exp_i,
  input  logic [MAN_W-1:0]  man_i,
  input  logic [1:0]        mode_i,
  output logic              out_valid_o,
  output logic [RES_W-1:0]  result_o,
  output logic              overflow_o,
  output logic              underflow_o,
  output logic              inexact_o
);
  rmode_e            mode;
  logic              inc, lost, carry;
  logic [EXPI_W:0]   exp_adj;
  logic [FRAC_W-1:0] frac_adj;
  logic [RES_W-1:0]  res_nxt;
  logic              ovf_nxt, unf_nxt, inx_nxt;

  assign mode = rmode_e'(mode_i);

  fprnd_incr_decide u_decide (
    .sign_i   (sign_i),
    .mode_i   (mode),
    .lsb_i    (man_i[2]),
    .guard_i  (man_i[1]),
    .sticky_i (man_i[0]),
    .inc_o    (inc),
    .lost_o   (lost)
  );

  fprnd_mant_adjust #(.FRAC_W(FRAC_W), .EXPI_W(EXPI_W)) u_adjust (
    .exp_i   (exp_i),
    .sig_i   (man_i[MAN_W-2:2]),
    .inc_i   (inc),
    .exp_o   (exp_adj),
    .frac_o  (frac_adj),
    .carry_o (carry)
  );

  fprnd_pack_sat #(.FRAC_W(FRAC_W), .EXP_W(EXP_W), .EXPI_W(EXPI_W)) u_pack (
    .sign_i   (sign_i),
    .mode_i   (mode),
    .exp_i    (exp_adj),
    .frac_i   (frac_adj),
    .lost_i   (lost),
    .result_o (res_nxt),
    .ovf_o    (ovf_nxt),
    .unf_o    (unf_nxt),
    .inx_o    (inx_nxt)
  );

  // output register, loaded only on an operand strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
      overflow_o  <= 1'b0;
      underflow_o <= 1'b0;
      inexact_o   <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        result_o    <= res_nxt;
        overflow_o  <= ovf_nxt;
        underflow_o <= unf_nxt;
        inexact_o   <= inx_nxt;
      end
    end
  end

  // R1: output strobe follows input strobe by one cycle
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> out_valid_o);
  a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> !out_valid_o);
  // R3: toward-zero never enlarges the kept mantissa
  a_r3_no_bump: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && mode_i == 2'd1 && !carry) |-> frac_adj == man_i[FRAC_W+1:2]);
  // R6: a carry out of the leading bit raises the exponent by exactly one
  a_r6_carry_exp: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && carry) |-> exp_adj == {1'b0, exp_i} + 1'b1);
  // R8: overflow always yields infinity or the largest finite exponent
  a_r8_ovf_exp_field: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && overflow_o) |->
      (result_o[RES_W-2:FRAC_W] == EXP_W'(EXP_TOP) ||
       result_o[RES_W-2:FRAC_W] == EXP_W'(EXP_TOP - 1)));
  // R9: lost guard or sticky bits always show up as inexact
  a_r9_inexact_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && man_i[1:0] != 2'b00) |=> inexact_o);
  // R10: underflow only with a zero exponent field and never with overflow
  a_r10_unf_tiny: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && underflow_o) |->
      (result_o[RES_W-2:FRAC_W] == '0 && inexact_o && !overflow_o));
  // R11: idle cycles leave the result untouched
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> $stable(result_o) && $stable(inexact_o));
endmodule

// File: tb/fprnd_round_unit_tb_top.sv
module fprnd_round_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid_i;
  logic        sign_i;
  logic [11:0] exp_i;
  logic [55:0] man_i;
  logic [1:0]  mode_i;
  logic        out_valid_o;
  logic [63:0] result_o;
  logic        overflow_o, underflow_o, inexact_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic [63:0] res;
    logic        ovf, unf, inx;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  localparam logic [51:0] F_ONES = {52{1'b1}};

  always #10 clk = ~clk;  // 50 MHz

  fprnd_round_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .sign_i(sign_i),
    .exp_i(exp_i), .man_i(man_i), .mode_i(mode_i), .out_valid_o(out_valid_o),
    .result_o(result_o), .overflow_o(overflow_o), .underflow_o(underflow_o),
    .inexact_o(inexact_o)
  );

  // Reference: exponent and fraction joined into one integer, so a rounding
  // carry propagates into the exponent on its own.
  function automatic exp_t model(input logic s, input logic [11:0] e,
                                 input logic [51:0] f, input logic g,
                                 input logic st, input logic [1:0] m,
                                 input string tag);
    exp_t r;
    logic [63:0] comb;
    logic up, lost, inf;
    lost = g | st;
    case (m)
      2'd0: up = g & (st | f[0]);
      2'd1: up = 1'b0;
      2'd2: up = lost & !s;
      default: up = lost & s;
    endcase
    comb = {e, f} + 64'(up);
    r.tag = tag;
    if (comb[63:52] >= 12'd2047) begin
      inf = (m == 2'd0) || (m == 2'd2 && !s) || (m == 2'd3 && s);
      r.res = inf ? {s, 11'd2047, 52'd0} : {s, 11'd2046, F_ONES};
      r.ovf = 1'b1;
      r.inx = 1'b1;
      r.unf = 1'b0;
    end else begin
      r.res = {s, comb[62:0]};
      r.ovf = 1'b0;
      r.inx = lost;
      r.unf = (comb[63:52] == 12'd0) && lost;
    end
    return r;
  endfunction

  task automatic drive(input logic s, input logic [11:0] e, input logic [51:0] f,
                       input logic g, input logic st, input logic [1:0] m,
                       input string tag);
    @(negedge clk);
    in_valid_i = 1'b1;
    sign_i = s;
    exp_i = e;
    man_i = {1'b0, (e != 12'd0), f, g, st};
    mode_i = m;
    sb_q.push_back(model(s, e, f, g, st, m, tag));
    @(negedge clk);
    in_valid_i = 1'b0;
  endtask

  task automatic check_item(input exp_t x);
    checks++;
    if (result_o !== x.res || overflow_o !== x.ovf || underflow_o !== x.unf ||
        inexact_o !== x.inx) begin
      failures++;
      $display("FAIL %s: got res=%h o/u/i=%b%b%b expected res=%h o/u/i=%b%b%b",
               x.tag, result_o, overflow_o, underflow_o, inexact_o,
               x.res, x.ovf, x.unf, x.inx);
    end
  endtask

  // monitor: pops one expected item per output strobe
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && out_valid_o) begin
        if (sb_q.size() == 0) begin
          checks++; failures++;
          $display("FAIL R1: unexpected out_valid_o, got 1 expected 0");
        end else begin
          check_item(sb_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid_i = 1'b0; sign_i = 1'b0; exp_i = '0; man_i = '0; mode_i = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid_o !== 1'b0 || result_o !== 64'd0 || overflow_o || underflow_o || inexact_o) begin
      failures++;
      $display("FAIL R1: reset state got v=%b res=%h expected 0", out_valid_o, result_o);
    end
    rst_n = 1'b1;
    @(negedge clk);

    drive(0, 12'd1023, 52'd0, 1, 0, 2'd0, "R2 tie even");
    drive(0, 12'd1023, 52'd1, 1, 0, 2'd0, "R2 tie odd");
    drive(1, 12'd1000, 52'd4, 1, 1, 2'd0, "R2 above half");
    drive(0, 12'd1000, 52'd7, 0, 1, 2'd0, "R2 below half");
    drive(0, 12'd1023, 52'd9, 1, 1, 2'd1, "R3 pos");
    drive(1, 12'd1023, 52'd9, 1, 1, 2'd1, "R3 neg");
    drive(0, 12'd900,  52'd5, 0, 1, 2'd2, "R4 pos");
    drive(1, 12'd900,  52'd5, 0, 1, 2'd2, "R4 neg");
    drive(1, 12'd900,  52'd5, 1, 0, 2'd3, "R5 neg");
    drive(0, 12'd900,  52'd5, 1, 0, 2'd3, "R5 pos");
    drive(0, 12'd1023, F_ONES, 1, 1, 2'd0, "R6 carry");
    drive(1, 12'd10,   F_ONES, 0, 1, 2'd3, "R6 carry neg");
    drive(0, 12'd2046, F_ONES, 1, 0, 2'd0, "R8 carry into inf");
    drive(0, 12'd2050, 52'd3, 0, 0, 2'd0, "R8 rne pos");
    drive(1, 12'd2047, 52'd3, 0, 0, 2'd1, "R8 rz neg");
    drive(0, 12'd2047, 52'd3, 0, 0, 2'd2, "R8 up pos");
    drive(1, 12'd2047, 52'd3, 0, 0, 2'd2, "R8 up neg");
    drive(0, 12'd2047, 52'd3, 0, 0, 2'd3, "R8 down pos");
    drive(1, 12'd2047, 52'd3, 0, 0, 2'd3, "R8 down neg");
    drive(0, 12'd2046, F_ONES, 1, 1, 2'd1, "R8 no ovf rz");
    drive(0, 12'd0, F_ONES, 1, 0, 2'd0, "R7 subnormal promotes");
    drive(1, 12'd0, F_ONES, 0, 1, 2'd3, "R7 subnormal promotes neg");
    drive(0, 12'd0, 52'd5, 0, 1, 2'd1, "R10 tiny inexact");
    drive(0, 12'd0, 52'd5, 0, 0, 2'd0, "R10 exact subnormal");
    drive(1, 12'd0, 52'd0, 0, 0, 2'd0, "R10 zero");
    drive(0, 12'd1500, 52'd77, 0, 0, 2'd2, "R9 exact normal");
    drive(0, 12'd1200, 52'd6, 1, 1, 2'd2, "R9 last value");

    // R11: idle cycles must not disturb the held result
    repeat (4) @(negedge clk);
    checks++;
    if (result_o !== {1'b0, 11'd1200, 52'd7} || inexact_o !== 1'b1) begin
      failures++;
      $display("FAIL R11: hold got res=%h inx=%b expected %h 1",
               result_o, inexact_o, {1'b0, 11'd1200, 52'd7});
    end
    checks++;
    if (sb_q.size() != 0) begin
      failures++;
      $display("FAIL R1: missing results got %0d pending expected 0", sb_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule